// File: doc/BRIEF.md
# Hall Sensor State Decoder

This block reads two or three digital position sensors of a brushless motor and a direction bit supplied by the host, and produces a 4-bit state number for the commutation output stage that follows it. The sensor lines are asynchronous to the block clock and pass through a two-flop synchroniser before they are decoded. The direction bit and the sensor-count mode bit are static configuration inputs driven from the host clock domain.

Each time the state number changes, the block raises a single-cycle update strobe so that the downstream commutation stage can latch the new value. A change of the direction bit alone also counts as a change. In three-sensor mode, the two sensor codes that cannot occur on a healthy motor (all low and all high) are flagged on an error output. The decoder is not tied to motors: any small set of slow digital inputs, such as option switches, can be read through it.

Top module: `hall_state_decoder`

## Requirements
- R1: `stateOut` packs the state as follows: bit 3 is the direction bit, and bits 2:0 are the synchronised sensor code, with bit i taken from `sensorIn[i]`.
- R2: When `threeSensorMode` is 1, all three code bits follow sensors 2, 1 and 0.
- R3: When `threeSensorMode` is 0, code bit 2 is forced to 0. Changes on `sensorIn[2]` then have no effect on `stateOut` or on `updateStrobe`.
- R4: Each sensor input passes through two synchronising flops. A sensor value that is set up before clock edge k appears on `stateOut` after edge k+2. A change of `dirIn` or `threeSensorMode` appears after the first edge.
- R5: `updateStrobe` is high for exactly one clock, in the cycle in which `stateOut` first shows a new value. This includes a change that comes only from the direction bit.
- R6: `updateStrobe` stays low while `stateOut` does not change.
- R7: `codeError` is 1 exactly when three-sensor mode is active and the displayed code is 000 or 111. It is registered together with `stateOut` and is never 1 in two-sensor mode.
- R8: While `rstN` is low, `stateOut`, `updateStrobe` and `codeError` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sensorIn | input | 3 | Raw asynchronous sensor lines |
| threeSensorMode | input | 1 | 1 selects three-sensor decoding, 0 selects two-sensor decoding |
| dirIn | input | 1 | Direction bit from the host |
| stateOut | output | 4 | State number: {direction, code[2:0]} |
| updateStrobe | output | 1 | One-cycle pulse when stateOut changes |
| codeError | output | 1 | Invalid three-sensor code flag |

## Verification
The assertions assume that `dirIn` and `threeSensorMode` are synchronous to `clk`. They also assume that a sensor level, once applied, is held long enough to cross the synchroniser. The bench respects both assumptions: it changes all inputs only on the falling edge and holds each input vector for five clocks before it checks the result. Within that window the bench predicts the strobe count from two steps, because a direction or mode change reaches the output two cycles ahead of a sensor change applied at the same moment.

// File: rtl/hall_dec_pkg.sv
package hall_dec_pkg;
  localparam int SENSOR_W = 3;
  localparam int STATE_W  = SENSOR_W + 1;

  typedef struct packed {
    logic loadState;
    logic errNext;
  } hallCtrl_t;

  function automatic logic isBadCode(input logic [SENSOR_W-1:0] code);
    return (code == '0) || (code == '1);
  endfunction
endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar b = 0; b < WIDTH; b++) begin : gBit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[STAGES-1];
  end

  // R4
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN, 2) |-> (syncOut == $past(asyncIn, 2)));
endmodule

// File: rtl/hall_datapath.sv
module hall_datapath
  import hall_dec_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [SENSOR_W-1:0] syncSensors,
  input  logic                threeMode,
  input  logic                dirBit,
  input  hallCtrl_t           ctrl,
  output logic [STATE_W-1:0]  nextState,
  output logic [STATE_W-1:0]  stateQ,
  output logic                errQ
);
  logic [SENSOR_W-1:0] codeMasked;

  always_comb begin
    codeMasked = syncSensors;
    if (!threeMode) codeMasked[SENSOR_W-1] = 1'b0;
    nextState = {dirBit, codeMasked};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= '0;
      errQ   <= 1'b0;
    end else begin
      if (ctrl.loadState) stateQ <= nextState;
      errQ <= ctrl.errNext;
    end
  end

  // R3
  two_sensor_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(threeMode) |-> !stateQ[SENSOR_W-1]);

  // R7
  err_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> (isBadCode(stateQ[SENSOR_W-1:0]) && $past(threeMode)));
endmodule

// File: rtl/hall_control.sv
module hall_control
  import hall_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] nextState,
  input  logic [STATE_W-1:0] stateQ,
  input  logic               threeMode,
  output hallCtrl_t          ctrl,
  output logic               updateStrobe
);
  always_comb begin
    ctrl.loadState = (nextState != stateQ);
    ctrl.errNext   = threeMode && isBadCode(nextState[SENSOR_W-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) updateStrobe <= 1'b0;
    else       updateStrobe <= ctrl.loadState;
  end
endmodule

// File: rtl/hall_state_decoder.sv
module hall_state_decoder
  import hall_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] sensorIn,
  input  logic       threeSensorMode,
  input  logic       dirIn,
  output logic [3:0] stateOut,
  output logic       updateStrobe,
  output logic       codeError
);
  logic [SENSOR_W-1:0] syncSensors;
  logic [STATE_W-1:0]  nextState;
  hallCtrl_t           ctrl;

  hall_sync #(.WIDTH(SENSOR_W), .STAGES(2)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(sensorIn), .syncOut(syncSensors)
  );

  hall_datapath uDp (
    .clk(clk), .rstN(rstN), .syncSensors(syncSensors),
    .threeMode(threeSensorMode), .dirBit(dirIn), .ctrl(ctrl),
    .nextState(nextState), .stateQ(stateOut), .errQ(codeError)
  );

  hall_control uCtl (
    .clk(clk), .rstN(rstN), .nextState(nextState), .stateQ(stateOut),
    .threeMode(threeSensorMode), .ctrl(ctrl), .updateStrobe(updateStrobe)
  );

  // R5
  strobe_on_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut != $past(stateOut)) |-> updateStrobe);

  // R6
  no_idle_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    updateStrobe |-> (stateOut != $past(stateOut)));

  // R1
  dir_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateOut[3] == $past(dirIn));
endmodule

// File: tb/tb_hall_state_decoder.sv
module tb_hall_state_decoder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] sensorIn = '0;
  logic       threeSensorMode = 1'b0;
  logic       dirIn = 1'b0;
  logic [3:0] stateOut;
  logic       updateStrobe;
  logic       codeError;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  bit done = 0;

  logic [2:0] curSens = '0;
  logic       curMode = 1'b0;
  logic       curDir  = 1'b0;

  always #10 clk = ~clk;

  hall_state_decoder dut (
    .clk(clk), .rstN(rstN), .sensorIn(sensorIn),
    .threeSensorMode(threeSensorMode), .dirIn(dirIn),
    .stateOut(stateOut), .updateStrobe(updateStrobe), .codeError(codeError)
  );

  always @(negedge clk) if (rstN && updateStrobe) pulseCnt++;

  function automatic logic [3:0] expState(input logic [2:0] s, input logic m, input logic d);
    return {d, (m ? s[2] : 1'b0), s[1], s[0]};
  endfunction

  function automatic logic expErr(input logic [2:0] s, input logic m);
    return m && (s == 3'b000 || s == 3'b111);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply a vector, wait for it to settle, and check state, error and pulse count.
  task automatic step(input logic [2:0] s, input logic m, input logic d, input string req);
    logic [3:0] prevE, midE, finE;
    int base, expPulses;
    prevE = expState(curSens, curMode, curDir);
    midE  = expState(curSens, m, d);
    finE  = expState(s, m, d);
    expPulses = int'(midE != prevE) + int'(finE != midE);
    @(negedge clk);
    base = pulseCnt;
    sensorIn = s; threeSensorMode = m; dirIn = d;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check({req, " state"}, stateOut, finE);
    check("R7 error", codeError, expErr(s, m));
    check({req, " R5/R6 pulses"}, pulseCnt - base, expPulses);
    curSens = s; curMode = m; curDir = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 state", stateOut, 0);
    check("R8 strobe", updateStrobe, 0);
    check("R8 error", codeError, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 three-sensor decoding, R7 invalid codes
    step(3'b101, 1'b1, 1'b0, "R2");
    step(3'b111, 1'b1, 1'b0, "R7 code 111");
    step(3'b000, 1'b1, 1'b0, "R7 code 000");
    step(3'b011, 1'b1, 1'b0, "R2");
    // R1 direction-only change still strobes once
    step(3'b011, 1'b1, 1'b1, "R1 R5 dir only");
    // R3 two-sensor mode masks bit 2
    step(3'b011, 1'b0, 1'b1, "R3");
    step(3'b111, 1'b0, 1'b1, "R3 R6 sensor2 ignored");
    step(3'b000, 1'b0, 1'b1, "R3 no error 000");
    step(3'b000, 1'b0, 1'b1, "R6 no change");

    // R4 latency: sensor shows after third edge, not the second
    @(negedge clk);
    threeSensorMode = 1'b1; sensorIn = 3'b010;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R4 before sync", stateOut, expState(3'b000, 1'b1, 1'b1));
    @(negedge clk);
    check("R4 after sync", stateOut, expState(3'b010, 1'b1, 1'b1));
    check("R4 R5 strobe", updateStrobe, 1);
    @(negedge clk);
    check("R5 one cycle", updateStrobe, 0);
    // R4 direction reaches the output after one edge
    dirIn = 1'b0;
    @(negedge clk);
    check("R4 dir latency", stateOut, expState(3'b010, 1'b1, 1'b0));
    curSens = 3'b010; curMode = 1'b1; curDir = 1'b0;
    repeat (4) @(negedge clk);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      logic [2:0] s;
      logic m, d;
      s = 3'($urandom);
      m = ($urandom % 4) != 0;
      d = ($urandom % 3) == 0 ? ~curDir : curDir;
      step(s, m, d, "R1 R2 R3 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule